// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Timing Tracker

This block watches the command stream that a memory controller sends to a four-bank SDRAM and keeps a timing model of every bank. Each clock it takes one decoded command, the bank it targets, the CAS latency, the burst-length code and the write-mode bits. From these it works out when each bank closes, whether by an explicit precharge or by the internal precharge that a read or write with auto-precharge starts. It then works out the earliest clock at which that bank may be opened again.

The controller uses the per-bank ready flags to schedule row activations. A single violation flag reports any command that the device would not accept at that point. Such commands include an activation of a busy bank, a column access that comes too soon after activation, and any access to a bank that is closing by itself. An illegal command is reported and leaves the model unchanged.

The start of an internal precharge after a read is tied to the final data beat and to the CAS latency. It is held back until the minimum open time of the row has passed. A write with auto-precharge closes the bank once its last data beat has been taken. Write data enters on the command clock. In single-write mode a write covers exactly one column.

Top module: `sdr_bank_tracker`

## Requirements
- R1: A synchronous active-high reset puts every bank in the idle state with its counters cleared. In the cycle after a reset edge all `bank_ready` bits are 1 and `violation` is 0.
- R2: `cmd` encodes 0 no-op, 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 write with auto-precharge, 6 precharge, and 7 is treated as a no-op. `bank` selects one of four banks, and a command changes only the bank it selects.
- R3: An activate sent to a bank whose ready bit is 0 is ignored and sets `violation`. `violation` is registered: it is high for exactly the one cycle after the clock edge that sampled an illegal command, and it is low after any legal command or no-op.
- R4: A read or write (with or without auto-precharge) that reaches a bank fewer than `T_RCD` clocks after that bank's activate edge is ignored and flagged. A column command on a bank that is not open is also ignored and flagged.
- R5: A read with auto-precharge issued at edge E starts the internal precharge at edge E + CL + BL − 1 − k, where k is 2 when `cas_lat` is 3 and 1 when `cas_lat` is 2. Any `cas_lat` value other than 3 means CL = 2. `bl_code` 0/1/2/3 gives BL 1/2/4/8.
- R6: The internal precharge never starts before edge A + `T_RAS`, where A is the activate edge of that bank. A later start point is kept and an earlier one is moved to that edge.
- R7: From a read or write with auto-precharge until that bank is next activated, every read, write or precharge sent to that bank is ignored and flagged.
- R8: A write with auto-precharge issued at edge E starts the internal precharge at edge E + N (subject to R6), where N is the number of data beats. Data enters with zero latency. N is 1 when `wmode` is 2'b10 (single write) and BL otherwise.
- R9: A precharge sent to an open bank starts its precharge at that same edge. A precharge sent to a bank that is not open is ignored and flagged.
- R10: After a precharge starts at edge S, the bank's ready bit is 1 from the cycle before edge S + `T_APR` on. An activate is legal exactly when the ready bit of its bank is 1, and an accepted activate clears that bit in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code (see R2) |
| bank | input | 2 | Target bank of the command |
| cas_lat | input | 2 | CAS latency, 3 or 2 |
| bl_code | input | 2 | Burst-length code, BL = 1 << code |
| wmode | input | 2 | Write-mode bits; 2'b10 selects single write |
| bank_ready | output | 4 | Per bank: an activate would be legal on the next edge |
| violation | output | 1 | The command sampled on the last edge was illegal |

## Verification
`violation` is due in the cycle right after the edge that samples the command. A ready bit rises in the cycle before edge S + `T_APR`, so after a closing command at edge E the bench sees it on the falling edge that follows edge E + w + `T_APR` − 1. Here w is the start offset from R5, R6, R8 or R9. The bench drives inputs on falling edges and advances a behavioural per-bank model on each rising edge. On the next falling edge it compares both outputs with the model, so every result is checked in the exact cycle it is due. Separate latency measurements count the falling edges from a closing command until the ready bit appears, and compare that count with w + `T_APR` − 1 worked out from the parameters.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_RDA = 3'd3,
      CMD_WR  = 3'd4,
      CMD_WRA = 3'd5,
      CMD_PRE = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      BS_IDLE   = 2'd0,
      BS_OPEN   = 2'd1,
      BS_APWAIT = 2'd2,
      BS_PRECH  = 2'd3
   } bstate_e;

   localparam int MAX_BL = 8;

   // number of beats for a burst-length code
   function automatic int burst_beats(input logic [1:0] code);
      return 1 << code;
   endfunction

   // effective CAS latency: 3 selects three, everything else two
   function automatic int cl_value(input logic [1:0] c);
      return (c == 2'd3) ? 3 : 2;
   endfunction

   // clocks from a read command to the internal precharge start
   function automatic int rd_ap_offset(input logic [1:0] c, input logic [1:0] blc);
      int cl;
      int lead;
      cl   = cl_value(c);
      lead = (cl == 3) ? 2 : 1;
      return cl + burst_beats(blc) - 1 - lead;
   endfunction

   // clocks from a write command to the internal precharge start
   function automatic int wr_ap_offset(input logic [1:0] blc, input logic [1:0] wm);
      return (wm == 2'b10) ? 1 : burst_beats(blc);
   endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
   import sdr_trk_pkg::*;
#(
   parameter int NBANKS = 4,
   parameter int BANK_W = 2,
   parameter int WAIT_W = 4
) (
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [1:0]        cas_lat,
   input  logic [1:0]        bl_code,
   input  logic [1:0]        wmode,
   output cmd_e              op,
   output logic [NBANKS-1:0] sel,
   output logic [WAIT_W-1:0] rd_off,
   output logic [WAIT_W-1:0] wr_off
);

   always_comb begin
      if (cmd == 3'd7) op = CMD_NOP;
      else             op = cmd_e'(cmd);
   end

   for (genvar g = 0; g < NBANKS; g++) begin : g_sel
      assign sel[g] = (bank == BANK_W'(g)) && (op != CMD_NOP);
   end

   assign rd_off = WAIT_W'(rd_ap_offset(cas_lat, bl_code));
   assign wr_off = WAIT_W'(wr_ap_offset(bl_code, wmode));

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
   import sdr_trk_pkg::*;
#(
   parameter int T_RAS  = 5,
   parameter int T_APR  = 3,
   parameter int T_RCD  = 2,
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  cmd_e              op,
   input  logic [WAIT_W-1:0] rd_off,
   input  logic [WAIT_W-1:0] wr_off,
   output logic              ready,
   output logic              viol
);

   localparam int AGE_MAX = (T_RAS > T_RCD) ? T_RAS : T_RCD;
   localparam int AGE_W   = $clog2(AGE_MAX + 1);

   bstate_e           st_q, st_d;
   logic [AGE_W-1:0]  age_q;
   logic [WAIT_W-1:0] wait_q, wait_d;
   logic [WAIT_W-1:0] ras_rem, ap_off, ap_wait;
   logic              legal, take, start_pre;
   logic              apr_last, apr_zero;

   // legality of the presented command for this bank
   always_comb begin
      case (op)
         CMD_ACT:                        legal = (st_q == BS_IDLE) && apr_zero;
         CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: legal = (st_q == BS_OPEN) && (age_q >= AGE_W'(T_RCD));
         CMD_PRE:                        legal = (st_q == BS_OPEN);
         default:                        legal = 1'b1;
      endcase
   end

   assign take = sel && legal;
   assign viol = sel && !legal;

   // clocks still missing to the minimum row-open time
   always_comb begin
      if (age_q >= AGE_W'(T_RAS)) ras_rem = '0;
      else                        ras_rem = WAIT_W'(T_RAS) - WAIT_W'(age_q);
   end

   assign ap_off  = (op == CMD_RDA) ? rd_off : wr_off;
   assign ap_wait = (ap_off > ras_rem) ? ap_off : ras_rem;

   assign start_pre = ((st_q == BS_APWAIT) && (wait_q == WAIT_W'(1)))
                   || (take && (op == CMD_PRE));

   always_comb begin
      st_d   = st_q;
      wait_d = wait_q;
      case (st_q)
         BS_IDLE:   if (take && op == CMD_ACT) st_d = BS_OPEN;
         BS_OPEN:   if (take && (op == CMD_RDA || op == CMD_WRA)) begin
                       st_d   = BS_APWAIT;
                       wait_d = ap_wait;
                    end
         BS_APWAIT: if (wait_q != WAIT_W'(1)) wait_d = wait_q - WAIT_W'(1);
         BS_PRECH:  if (apr_last) st_d = BS_IDLE;
         default:   st_d = BS_IDLE;
      endcase
      if (start_pre) st_d = (T_APR > 1) ? BS_PRECH : BS_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= BS_IDLE;
         wait_q <= '0;
      end else begin
         st_q   <= st_d;
         wait_q <= wait_d;
      end
   end

   // row age since activation, saturating
   always_ff @(posedge clk) begin
      if (rst)                               age_q <= '0;
      else if (take && op == CMD_ACT)        age_q <= AGE_W'(1);
      else if (age_q < AGE_W'(AGE_MAX))      age_q <= age_q + AGE_W'(1);
   end

   // precharge recovery counter, absent when one clock suffices
   if (T_APR > 1) begin : g_apr_cnt
      localparam int APR_W = $clog2(T_APR);
      logic [APR_W-1:0] apr_q;
      always_ff @(posedge clk) begin
         if (rst)                 apr_q <= '0;
         else if (start_pre)      apr_q <= APR_W'(T_APR - 1);
         else if (apr_q != '0)    apr_q <= apr_q - APR_W'(1);
      end
      assign apr_last = (apr_q == APR_W'(1));
      assign apr_zero = (apr_q == '0);
   end else begin : g_apr_none
      assign apr_last = 1'b1;
      assign apr_zero = 1'b1;
   end

   assign ready = (st_q == BS_IDLE) && apr_zero;

endmodule

// File: rtl/sdr_viol_reg.sv
module sdr_viol_reg #(
   parameter int NBANKS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NBANKS-1:0] bank_viol,
   output logic              violation
);

   always_ff @(posedge clk) begin
      if (rst) violation <= 1'b0;
      else     violation <= |bank_viol;
   end

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
   import sdr_trk_pkg::*;
#(
   parameter int NBANKS = 4,
   parameter int T_RAS  = 5,
   parameter int T_APR  = 3,
   parameter int T_RCD  = 2,
   localparam int BANK_W   = $clog2(NBANKS),
   localparam int WAIT_MAX = (T_RAS > MAX_BL) ? T_RAS : MAX_BL,
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [1:0]        cas_lat,
   input  logic [1:0]        bl_code,
   input  logic [1:0]        wmode,
   output logic [NBANKS-1:0] bank_ready,
   output logic              violation
);

   initial begin
      assert (NBANKS >= 2 && (1 << BANK_W) == NBANKS)
         else $error("NBANKS must be a power of two");
      assert (T_APR >= 1) else $error("T_APR must be at least 1");
      assert (T_RCD >= 1) else $error("T_RCD must be at least 1");
      assert (T_RAS >= 1) else $error("T_RAS must be at least 1");
   end

   cmd_e              op;
   logic [NBANKS-1:0] sel;
   logic [NBANKS-1:0] bank_viol;
   logic [WAIT_W-1:0] rd_off, wr_off;

   sdr_cmd_decode #(
      .NBANKS (NBANKS),
      .BANK_W (BANK_W),
      .WAIT_W (WAIT_W)
   ) u_dec (
      .cmd     (cmd),
      .bank    (bank),
      .cas_lat (cas_lat),
      .bl_code (bl_code),
      .wmode   (wmode),
      .op      (op),
      .sel     (sel),
      .rd_off  (rd_off),
      .wr_off  (wr_off)
   );

   for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      sdr_bank_fsm #(
         .T_RAS  (T_RAS),
         .T_APR  (T_APR),
         .T_RCD  (T_RCD),
         .WAIT_W (WAIT_W)
      ) u_fsm (
         .clk    (clk),
         .rst    (rst),
         .sel    (sel[g]),
         .op     (op),
         .rd_off (rd_off),
         .wr_off (wr_off),
         .ready  (bank_ready[g]),
         .viol   (bank_viol[g])
      );
   end

   sdr_viol_reg #(.NBANKS(NBANKS)) u_viol (
      .clk       (clk),
      .rst       (rst),
      .bank_viol (bank_viol),
      .violation (violation)
   );

endmodule

// File: rtl/sdr_trk_chk.sv
module sdr_trk_chk
   import sdr_trk_pkg::*;
#(
   parameter int NBANKS = 4,
   parameter int T_RCD  = 2,
   localparam int BANK_W = $clog2(NBANKS)
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        cmd,
   input logic [BANK_W-1:0] bank,
   input logic [NBANKS-1:0] bank_ready,
   input logic              violation
);

   // R1
   reset_ready_chk: assert property (@(posedge clk)
      rst |=> (bank_ready == '1 && !violation));

   // R3
   actv_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && !bank_ready[bank]) |=> violation);

   // R3
   nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_NOP || cmd == 3'd7) |=> !violation);

   // R10
   actv_claims_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && bank_ready[bank]) |=> !bank_ready[$past(bank)]);

   // R9
   pre_closed_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE && bank_ready[bank]) |=> violation);

   // R4
   rcd_early_chk: assert property (@(posedge clk) disable iff (rst)
      (T_RCD > 1 && cmd == CMD_ACT && bank_ready[bank]) ##1
      ((cmd == CMD_RD || cmd == CMD_RDA || cmd == CMD_WR || cmd == CMD_WRA)
       && bank == $past(bank)) |=> violation);

   // R2
   for (genvar g = 0; g < NBANKS; g++) begin : g_keep
      idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
         (bank_ready[g] && !(cmd == CMD_ACT && bank == BANK_W'(g))) |=> bank_ready[g]);
   end

endmodule

bind sdr_bank_tracker sdr_trk_chk #(
   .NBANKS (NBANKS),
   .T_RCD  (T_RCD)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd        (cmd),
   .bank       (bank),
   .bank_ready (bank_ready),
   .violation  (violation)
);

// File: tb/tb_sdr_bank_tracker.sv
module tb_sdr_bank_tracker;

   localparam int NB    = 4;
   localparam int T_RAS = 5;
   localparam int T_APR = 3;
   localparam int T_RCD = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    cmd = 3'd0;
   logic [1:0]    bank = 2'd0;
   logic [1:0]    cas_lat = 2'd3;
   logic [1:0]    bl_code = 2'd2;
   logic [1:0]    wmode = 2'd0;
   logic [NB-1:0] bank_ready;
   logic          violation;

   int    checks = 0;
   int    errors = 0;
   string phase = "R1";
   bit    chk_en = 1'b0;

   always #5 clk = ~clk;

   sdr_bank_tracker #(
      .NBANKS (NB),
      .T_RAS  (T_RAS),
      .T_APR  (T_APR),
      .T_RCD  (T_RCD)
   ) dut (
      .clk        (clk),
      .rst        (rst),
      .cmd        (cmd),
      .bank       (bank),
      .cas_lat    (cas_lat),
      .bl_code    (bl_code),
      .wmode      (wmode),
      .bank_ready (bank_ready),
      .violation  (violation)
   );

   // behavioural reference: per-bank open flag, pending close and times
   int n;
   bit m_open [NB];
   bit m_shut [NB];
   int m_act  [NB];
   int m_start[NB];
   bit exp_v;

   function automatic bit m_ready(int b, int t);
      return !m_open[b] && (!m_shut[b] || t >= m_start[b] + T_APR);
   endfunction

   function automatic int beats(logic [1:0] c);
      return 1 << c;
   endfunction

   function automatic int rd_off_ref(logic [1:0] c, logic [1:0] blc);
      int cl;
      cl = (c == 2'd3) ? 3 : 2;
      return cl + beats(blc) - 1 - ((cl == 3) ? 2 : 1);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_shut[b] = 0; m_act[b] = 0; m_start[b] = 0;
         end
         n = 0;
         exp_v = 0;
      end else begin
         int b;
         int off;
         b = int'(bank);
         exp_v = 0;
         case (cmd)
            3'd1: if (m_ready(b, n)) begin
                     m_open[b] = 1; m_shut[b] = 0; m_act[b] = n;
                  end else exp_v = 1;
            3'd2, 3'd4: if (!(m_open[b] && n - m_act[b] >= T_RCD)) exp_v = 1;
            3'd3, 3'd5: if (m_open[b] && n - m_act[b] >= T_RCD) begin
                     off = (cmd == 3'd3) ? rd_off_ref(cas_lat, bl_code)
                                         : ((wmode == 2'b10) ? 1 : beats(bl_code));
                     m_start[b] = (n + off > m_act[b] + T_RAS) ? n + off : m_act[b] + T_RAS;
                     m_open[b] = 0; m_shut[b] = 1;
                  end else exp_v = 1;
            3'd6: if (m_open[b]) begin
                     m_open[b] = 0; m_shut[b] = 1; m_start[b] = n;
                  end else exp_v = 1;
            default: ;
         endcase
         n = n + 1;
      end
   end

   // compare with the model on every falling edge
   always @(negedge clk) begin
      if (chk_en && !rst) begin
         logic [NB-1:0] er;
         for (int b = 0; b < NB; b++) er[b] = m_ready(b, n);
         checks++;
         if (bank_ready !== er) begin
            errors++;
            $display("FAIL %s ready at cycle %0d: got %b expected %b", phase, n, bank_ready, er);
         end
         checks++;
         if (violation !== exp_v) begin
            errors++;
            $display("FAIL %s violation at cycle %0d: got %b expected %b", phase, n, violation, exp_v);
         end
      end
   end

   task automatic issue(input int c, input int b);
      @(negedge clk);
      cmd  = 3'(c);
      bank = 2'(b);
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) issue(0, 0);
   endtask

   // activate bank b so that the next issue lands k clocks after it
   task automatic open_bank(input int b, input int k);
      issue(1, b);
      idle(k - 1);
   endtask

   // close bank b with command c; count falling edges until it is ready
   task automatic lat_meas(input int c, input int b, input int expv, input string tag);
      int cnt;
      cnt = 0;
      issue(c, b);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         cmd = 3'd0;
         if (bank_ready[b]) break;
         cnt++;
      end
      checks++;
      if (cnt != expv) begin
         errors++;
         $display("FAIL %s ready latency: got %0d expected %0d", tag, cnt, expv);
      end
   endtask

   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst = 1'b0;
            chk_en = 1'b1;
            @(negedge clk);
            checks++;
            if (bank_ready !== 4'hF || violation !== 1'b0) begin
               errors++;
               $display("FAIL R1 reset state: got %b/%b expected 1111/0", bank_ready, violation);
            end

            // R4: column access too soon after activate, then legal
            phase = "R4";
            issue(1, 0); issue(2, 0); issue(2, 0); issue(4, 0);
            issue(3, 1); idle(2);

            // R5: read auto-precharge CL3 BL4, open long enough
            phase = "R5";
            cas_lat = 2'd3; bl_code = 2'd2;
            lat_meas(6, 0, T_APR - 1, "R9");
            open_bank(0, 8);
            lat_meas(3, 0, 4 + T_APR - 1, "R5");
            cas_lat = 2'd2; bl_code = 2'd3;
            open_bank(0, 8);
            lat_meas(3, 0, 8 + T_APR - 1, "R5");

            // R6: start held back by the minimum open time
            phase = "R6";
            cas_lat = 2'd2; bl_code = 2'd0;
            open_bank(1, 2);
            lat_meas(3, 1, mx(1, T_RAS - 2) + T_APR - 1, "R6");

            // R8: write auto-precharge, burst and single write
            phase = "R8";
            bl_code = 2'd3; wmode = 2'b10;
            open_bank(2, 6);
            lat_meas(5, 2, 1 + T_APR - 1, "R8");
            wmode = 2'b00;
            open_bank(2, 6);
            lat_meas(5, 2, 8 + T_APR - 1, "R8");

            // R7: everything but activate refused while closing
            phase = "R7";
            bl_code = 2'd2; cas_lat = 2'd3;
            open_bank(3, 6);
            issue(3, 3); issue(2, 3); issue(4, 3); issue(6, 3); issue(1, 3);
            issue(5, 3); idle(12);

            // R9: precharge to an idle bank, and to an open bank
            phase = "R9";
            issue(6, 1); issue(1, 1); idle(3); issue(6, 1); issue(1, 1); idle(4);

            // R3: activate of busy bank, code 7 as no-op
            phase = "R3";
            issue(1, 2); issue(1, 2); issue(7, 2); idle(2); issue(6, 2); idle(4);

            // R2: banks kept apart
            phase = "R2";
            issue(1, 0); issue(1, 1); issue(1, 2); issue(1, 3);
            issue(6, 0); issue(3, 1); issue(5, 2); issue(2, 3); idle(12);
            issue(6, 3); idle(4);

            // R10: mixed stream against the model
            phase = "R10";
            for (int i = 0; i < 3000; i++) begin
               int c;
               c = ($urandom_range(0, 3) == 0) ? 1 : int'($urandom_range(0, 7));
               cas_lat = 2'($urandom_range(2, 3));
               bl_code = 2'($urandom_range(0, 3));
               wmode   = 2'($urandom_range(0, 3));
               issue(c, int'($urandom_range(0, 3)));
            end
            idle(20);
         end
         begin
            repeat (200000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule